// File: doc/BRIEF.md
# Codec Command/Status Slot Checker

This block sits behind a serial audio-link frame deserializer. It watches the tag slot and the two register-access slots of every frame, in both link directions. In the controller-to-codec direction it rebuilds register commands. In the codec-to-controller direction it rebuilds status replies. Each time the data slot of a frame has been seen, it issues one record holding the direction, the read flag, the register address, the 16-bit data, the ten data-request flags and an error vector.

The deserializer presents one slot per strobe. `slot_sel` gives the slot number (0 = tag, 1 = address, 2 = data; 3 is ignored). `slot_dir` gives the direction (0 = command, 1 = status). `slot_bits` carries the slot value: 20 bits for slots 1 and 2, or the 16-bit tag right-aligned in bits 15:0. The two directions keep separate frame state, so their slots may interleave freely.

Top module: `codec_cmd_checker`

## Requirements
- R1: A tag strobe (slot 0) starts a new frame for its direction and clears that direction's collected fields and errors. Tag bit 14 marks the address slot valid and tag bit 13 marks the data slot valid.
- R2: In the command direction (`slot_dir`=0), address-slot bit 19 is the read flag (1 = read, 0 = write) and bits 18:12 are the 7-bit register address. The record reports the request flags as zero.
- R3: In the command direction, any set bit in address-slot bits 11:0 sets error bit 0 (reserved field).
- R4: In the status direction (`slot_dir`=1), address-slot bits 18:12 are the address and bits 11:2 are the request flags. Bit 19 and bits 1:0 are reserved, and a set bit there sets error bit 0. The record's read flag is always 0.
- R5: Data-slot bits 19:4 are the 16-bit data. A set bit in data-slot bits 3:0 sets error bit 0. When the tag marks the data slot invalid, the data reads 0.
- R6: A valid address slot whose address has bit 0 set sets error bit 1 (odd address).
- R7: Error bit 2 (split transaction) is set when the address slot is valid, the data slot is invalid and the access is not a read. It is also set when the data slot is valid and the address slot is invalid.
- R8: `rec_stb` pulses for exactly one cycle, in the cycle after the data-slot strobe, and only when the tag of that frame marked slot 1 or slot 2 valid. A slot that the tag marks invalid contributes neither fields nor errors. A data slot with no tag since the last record produces no record.
- R9: Command and status frames are tracked independently, and `rec_dir` names the direction of each record.
- R10: While reset is asserted and after it is released, all outputs are zero until the first record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_stb | input | 1 | A slot value is present this cycle |
| slot_dir | input | 1 | 0 = command direction, 1 = status direction |
| slot_sel | input | 2 | Slot number: 0 tag, 1 address, 2 data, 3 ignored |
| slot_bits | input | 20 | Slot value, MSB first on the wire; tag in bits 15:0 |
| rec_stb | output | 1 | One-cycle record strobe |
| rec_dir | output | 1 | Direction of the record |
| rec_read | output | 1 | Read access |
| rec_addr | output | 7 | Register address |
| rec_data | output | 16 | Register data |
| rec_req | output | 10 | Data-request flags (status direction only) |
| rec_err | output | 3 | Bit 0 reserved field, bit 1 odd address, bit 2 split |

## Verification
The record is registered, so every field of it is due on the first rising edge after the data-slot strobe and stays valid for that one cycle only. The bench drives each slot on a falling edge. It then checks the record at the falling edge that follows the data-slot strobe, which is half a cycle after the record appears. When a check of one record shares a cycle with the strobe of the next slot, the bench samples in that same half-cycle. A record that should be absent is checked at the same point.

// File: rtl/codec_cmd_checker.sv
module codec_cmd_checker #(
  parameter int SLOT_W = 20,
  parameter int TAG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_stb,
  input  logic              slot_dir,
  input  logic [1:0]        slot_sel,
  input  logic [SLOT_W-1:0] slot_bits,
  output logic              rec_stb,
  output logic              rec_dir,
  output logic              rec_read,
  output logic [6:0]        rec_addr,
  output logic [15:0]       rec_data,
  output logic [9:0]        rec_req,
  output logic [2:0]        rec_err
);
  localparam int AW = 7;
  localparam int DW = 16;
  localparam int RW = 10;
  localparam int V1_BIT = TAG_W - 2;
  localparam int V2_BIT = TAG_W - 3;

  logic [1:0]    seen, v1, v2, rd;
  logic [AW-1:0] addr [2];
  logic [RW-1:0] req  [2];
  logic [1:0]    err  [2];

  wire d = slot_dir;
  wire rsv1 = d ? (slot_bits[SLOT_W-1] | (|slot_bits[1:0]))
                : (|slot_bits[SLOT_W-AW-2:0]);
  wire rsv2 = |slot_bits[SLOT_W-DW-1:0];
  wire split = (v1[d] & ~v2[d] & ~rd[d]) | (~v1[d] & v2[d]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= '0; v1 <= '0; v2 <= '0; rd <= '0;
      for (int i = 0; i < 2; i++) begin
        addr[i] <= '0; req[i] <= '0; err[i] <= '0;
      end
      rec_stb <= 1'b0; rec_dir <= 1'b0; rec_read <= 1'b0;
      rec_addr <= '0; rec_data <= '0; rec_req <= '0; rec_err <= '0;
    end else begin
      rec_stb <= 1'b0;
      if (slot_stb) begin
        case (slot_sel)
          2'd0: begin
            seen[d] <= 1'b1;
            v1[d]   <= slot_bits[V1_BIT];
            v2[d]   <= slot_bits[V2_BIT];
            rd[d]   <= 1'b0;
            addr[d] <= '0;
            req[d]  <= '0;
            err[d]  <= '0;
          end
          2'd1: if (seen[d] && v1[d]) begin
            rd[d]   <= ~d & slot_bits[SLOT_W-1];
            addr[d] <= slot_bits[SLOT_W-2 -: AW];
            req[d]  <= d ? slot_bits[RW+1:2] : '0;
            err[d]  <= {slot_bits[SLOT_W-AW-1], rsv1};
          end
          2'd2: if (seen[d]) begin
            seen[d] <= 1'b0;
            if (v1[d] || v2[d]) begin
              rec_stb  <= 1'b1;
              rec_dir  <= d;
              rec_read <= rd[d];
              rec_addr <= addr[d];
              rec_req  <= req[d];
              rec_data <= v2[d] ? slot_bits[SLOT_W-1 -: DW] : '0;
              rec_err  <= {split, err[d][1], err[d][0] | (v2[d] & rsv2)};
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/codec_cmd_checker_sva.sv
module codec_cmd_checker_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        slot_stb,
  input logic [1:0]  slot_sel,
  input logic        rec_stb,
  input logic        rec_dir,
  input logic        rec_read,
  input logic [6:0]  rec_addr,
  input logic [9:0]  rec_req,
  input logic [2:0]  rec_err
);
  a_r8_stb_after_data_slot: assert property (@(posedge clk) disable iff (!rst_n)
    rec_stb |-> $past(slot_stb && slot_sel == 2'd2));

  a_r4_status_never_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_stb && rec_dir) |-> !rec_read);

  a_r2_command_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_stb && !rec_dir) |-> rec_req == 10'd0);

  a_r6_odd_flag_matches: assert property (@(posedge clk) disable iff (!rst_n)
    rec_stb |-> (rec_err[1] == rec_addr[0]));

  a_r10_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !rec_stb);
endmodule

bind codec_cmd_checker codec_cmd_checker_sva u_sva (
  .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .slot_sel(slot_sel),
  .rec_stb(rec_stb), .rec_dir(rec_dir), .rec_read(rec_read),
  .rec_addr(rec_addr), .rec_req(rec_req), .rec_err(rec_err)
);

// File: tb/tb_codec_cmd_checker.sv
module tb_codec_cmd_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slot_stb = 1'b0;
  logic        slot_dir = 1'b0;
  logic [1:0]  slot_sel = 2'd0;
  logic [19:0] slot_bits = '0;
  logic        rec_stb, rec_dir, rec_read;
  logic [6:0]  rec_addr;
  logic [15:0] rec_data;
  logic [9:0]  rec_req;
  logic [2:0]  rec_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  codec_cmd_checker dut (
    .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .slot_dir(slot_dir),
    .slot_sel(slot_sel), .slot_bits(slot_bits), .rec_stb(rec_stb),
    .rec_dir(rec_dir), .rec_read(rec_read), .rec_addr(rec_addr),
    .rec_data(rec_data), .rec_req(rec_req), .rec_err(rec_err)
  );

  // {dir, tag, slot1, slot2, stb, read, addr, data, req, err}
  localparam int NV = 9;
  localparam logic [94:0] VEC [NV] = '{
    {1'b0, 16'h6000, 20'h26000, 20'hBEEF0, 1'b1, 1'b0, 7'h26, 16'hBEEF, 10'h000, 3'b000},
    {1'b0, 16'h4000, 20'hFC000, 20'h12345, 1'b1, 1'b1, 7'h7C, 16'h0000, 10'h000, 3'b000},
    {1'b0, 16'h4000, 20'h10000, 20'h00000, 1'b1, 1'b0, 7'h10, 16'h0000, 10'h000, 3'b100},
    {1'b0, 16'h6000, 20'h13001, 20'h55558, 1'b1, 1'b0, 7'h13, 16'h5555, 10'h000, 3'b011},
    {1'b1, 16'h6000, 20'h3AAA8, 20'h0F0F0, 1'b1, 1'b0, 7'h3A, 16'h0F0F, 10'h2AA, 3'b000},
    {1'b1, 16'h6000, 20'h82001, 20'h00000, 1'b1, 1'b0, 7'h02, 16'h0000, 10'h000, 3'b001},
    {1'b0, 16'h2000, 20'hFFFFF, 20'hABCD0, 1'b1, 1'b0, 7'h00, 16'hABCD, 10'h000, 3'b100},
    {1'b0, 16'h8000, 20'h26000, 20'hBEEF0, 1'b0, 1'b0, 7'h00, 16'h0000, 10'h000, 3'b000},
    {1'b0, 16'h6000, 20'h40800, 20'h00010, 1'b1, 1'b0, 7'h40, 16'h0001, 10'h000, 3'b001}
  };
  localparam string VREQ [NV] = '{"R1 R2", "R2 R7", "R7", "R3 R5 R6",
                                  "R4 R9", "R4", "R5 R7 R8", "R8", "R3"};

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic put(input logic dir, input logic [1:0] sel, input logic [19:0] bits);
    @(negedge clk);
    slot_stb = 1'b1; slot_dir = dir; slot_sel = sel; slot_bits = bits;
  endtask

  task automatic idle();
    @(negedge clk);
    slot_stb = 1'b0; slot_sel = 2'd3; slot_bits = '0;
  endtask

  task automatic chk_rec(input string r, input logic stb, input logic dir,
                         input logic rd, input logic [6:0] a, input logic [15:0] dt,
                         input logic [9:0] rq, input logic [2:0] e);
    chk({r, " stb"}, 64'(rec_stb), 64'(stb));
    if (stb) begin
      chk({r, " dir"}, 64'(rec_dir), 64'(dir));
      chk({r, " read"}, 64'(rec_read), 64'(rd));
      chk({r, " addr"}, 64'(rec_addr), 64'(a));
      chk({r, " data"}, 64'(rec_data), 64'(dt));
      chk({r, " req"}, 64'(rec_req), 64'(rq));
      chk({r, " err"}, 64'(rec_err), 64'(e));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: outputs during reset
    chk("R10 reset stb", 64'(rec_stb), 64'd0);
    chk("R10 reset fields", 64'({rec_dir, rec_read, rec_addr, rec_data, rec_req, rec_err}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after release", 64'({rec_stb, rec_addr, rec_data, rec_err}), 64'd0);

    for (int i = 0; i < NV; i++) begin
      put(VEC[i][94], 2'd0, {4'd0, VEC[i][93:78]});
      put(VEC[i][94], 2'd1, VEC[i][77:58]);
      put(VEC[i][94], 2'd2, VEC[i][57:38]);
      idle();
      chk_rec(VREQ[i], VEC[i][37], VEC[i][94], VEC[i][36], VEC[i][35:29],
              VEC[i][28:13], VEC[i][12:3], VEC[i][2:0]);
      @(negedge clk);
      chk({VREQ[i], " R8 single pulse"}, 64'(rec_stb), 64'd0);
    end

    // R8: data slot with no tag since the last record
    put(1'b0, 2'd2, 20'hBEEF0);
    idle();
    chk("R8 no tag no record", 64'(rec_stb), 64'd0);

    // R1: second tag clears errors from an earlier address slot
    put(1'b0, 2'd0, 20'h06000);
    put(1'b0, 2'd1, 20'h13FFF);
    put(1'b0, 2'd0, 20'h06000);
    put(1'b0, 2'd1, 20'h22000);
    put(1'b0, 2'd2, 20'h77770);
    idle();
    chk_rec("R1 tag restart", 1'b1, 1'b0, 1'b0, 7'h22, 16'h7777, 10'h0, 3'b000);

    // R9: interleaved directions
    put(1'b0, 2'd0, 20'h06000);
    put(1'b1, 2'd0, 20'h06000);
    put(1'b0, 2'd1, 20'h08000);
    put(1'b1, 2'd1, 20'h0A004);
    put(1'b0, 2'd2, 20'h11110);
    put(1'b1, 2'd2, 20'h22220);
    chk_rec("R9 command rec", 1'b1, 1'b0, 1'b0, 7'h08, 16'h1111, 10'h000, 3'b000);
    idle();
    chk_rec("R9 status rec", 1'b1, 1'b1, 1'b0, 7'h0A, 16'h2222, 10'h001, 3'b000);

    // R10: reset in mid-frame drops the frame
    put(1'b0, 2'd0, 20'h06000);
    put(1'b0, 2'd1, 20'h30000);
    @(negedge clk);
    slot_stb = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R10 reset clears record", 64'({rec_stb, rec_addr, rec_err}), 64'd0);
    put(1'b0, 2'd2, 20'h44440);
    idle();
    chk("R10 R8 no record after reset", 64'(rec_stb), 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule